// File: doc/BRIEF.md
# Floating-Point Compare and Condition Code Unit

This block compares two IEEE 754 operands under a selected relation and keeps the outcome in a one-bit condition register. Both operands are either single-precision or double-precision. The format is chosen per operation, and a single-precision operand sits in the low 32 bits of its 64-bit input. The comparison is unordered-aware: if either operand is NaN, the stored result is false, whatever relation was chosen.

The condition register is written only on cycles where the compare strobe is high, and it keeps its value at all other times. A branch decision is made from the stored bit. When the branch sense is "true", the branch is taken if the bit is 1. When the sense is "false", the branch is taken if the bit is 0. Because NaN forces false, the relations "less than" and "greater or equal" can both come out false for the same pair of operands.

Top module: `fp_cmp_cc`

## Requirements
- R1: On a compare, `cc` becomes the truth of `opa REL opb`. The relation codes are 0 = equal, 1 = greater-than, 2 = less-than, 3 = less-or-equal and 4 = greater-or-equal. Codes 5 to 7 store false.
- R2: With `fmt_dbl`=0, each operand is read as a single (sign bit 31, exponent bits 30:23, fraction bits 22:0), and bits 63:32 have no effect. With `fmt_dbl`=1, each operand is read as a double (sign bit 63, exponent bits 62:52, fraction bits 51:0).
- R3: If either operand is NaN, the compare stores 0 for every relation. NaN means an all-ones exponent with a nonzero fraction.
- R4: Positive zero and negative zero compare as equal.
- R5: Non-NaN values are ordered by sign-magnitude rules. Any negative value is below any positive value, and between two negatives the one with the larger magnitude is the smaller value.
- R6: An infinity is ordered beyond every finite value of its sign: +inf is greater than all finite values, and -inf is less than all finite values.
- R7: `cc` changes only on a rising clock edge where `cmp_en`=1. It holds its value otherwise, and it is 0 while `rst_n` is low.
- R8: `br_taken` equals `cc` when `br_sense`=1 and equals the inverse of `cc` when `br_sense`=0. Because it is read from the stored bit, a compare strobed in the same cycle affects `br_taken` only after the clock edge.
- R9: For operands that are not NaN, exactly one of "less than" and "greater or equal" is true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_en | input | 1 | Compare strobe; updates `cc` at the next edge |
| fmt_dbl | input | 1 | 0 = single-precision, 1 = double-precision |
| rel | input | 3 | Relation code (see R1) |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| br_sense | input | 1 | 1 = branch-on-true, 0 = branch-on-false |
| cc | output | 1 | Stored condition bit |
| br_taken | output | 1 | Branch decision from `cc` and `br_sense` |

## Verification
A new compare and a branch decision can fall in the same cycle: the strobe writes the condition bit while the branch logic reads it. The bench provokes this by raising `cmp_en` with operands whose result is the opposite of the stored bit, with `br_sense` high. It checks that `br_taken` still follows the old bit before the edge and the new bit after it. All other results are judged against an ordering key computed in the bench: the magnitude, negated when the sign is set. This key is swept over every pair of a table of signed zeros, denormals, normals, infinities and NaNs in both formats, under all relation codes.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  typedef enum logic [2:0] {
    REL_EQ = 3'd0,
    REL_GT = 3'd1,
    REL_LT = 3'd2,
    REL_LE = 3'd3,
    REL_GE = 3'd4
  } rel_e;

  // Maps the ordered flags to the chosen relation; unknown codes give false.
  function automatic logic rel_hit(input logic [2:0] code, input logic lt, input logic eq);
    case (code)
      REL_EQ:  return eq;
      REL_GT:  return !lt && !eq;
      REL_LT:  return lt;
      REL_LE:  return lt || eq;
      REL_GE:  return !lt;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int SE = 8,
  parameter int SF = 23,
  parameter int DE = 11,
  parameter int DF = 52,
  localparam int W  = 1 + DE + DF,
  localparam int MW = DE + DF,
  localparam int SW = SE + SF
) (
  input  logic [W-1:0]  op,
  input  logic          dbl,
  output logic          nan,
  output logic          sign,
  output logic          zero,
  output logic [MW-1:0] mag
);
  function automatic logic nan_dbl(input logic [MW-1:0] m);
    return (&m[MW-1:DF]) && (|m[DF-1:0]);
  endfunction

  function automatic logic nan_sgl(input logic [SW-1:0] m);
    return (&m[SW-1:SF]) && (|m[SF-1:0]);
  endfunction

  always_comb begin
    if (dbl) begin
      sign = op[W-1];
      mag  = op[MW-1:0];
      nan  = nan_dbl(op[MW-1:0]);
    end else begin
      sign = op[SW];
      mag  = MW'(op[SW-1:0]);
      nan  = nan_sgl(op[SW-1:0]);
    end
    zero = (mag == '0);
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int MW = 63
) (
  input  logic          sa,
  input  logic          sb,
  input  logic          za,
  input  logic          zb,
  input  logic [MW-1:0] ma,
  input  logic [MW-1:0] mb,
  output logic          lt,
  output logic          eq
);
  // Returns {lt, eq} for sign-magnitude values.
  function automatic logic [1:0] order_f(input logic a_neg, input logic b_neg,
                                         input logic both_zero,
                                         input logic [MW-1:0] x, input logic [MW-1:0] y);
    if (both_zero)          return 2'b01;
    else if (a_neg != b_neg) return {a_neg, 1'b0};
    else if (!a_neg)        return {x < y, x == y};
    else                    return {x > y, x == y};
  endfunction

  always_comb {lt, eq} = order_f(sa, sb, za && zb, ma, mb);
endmodule

// File: rtl/fpcmp_ccreg.sv
module fpcmp_ccreg (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/fp_cmp_cc.sv
module fp_cmp_cc #(
  parameter int SP_EXP  = 8,
  parameter int SP_FRAC = 23,
  parameter int DP_EXP  = 11,
  parameter int DP_FRAC = 52,
  localparam int DW = 1 + DP_EXP + DP_FRAC,
  localparam int MW = DP_EXP + DP_FRAC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_en,
  input  logic          fmt_dbl,
  input  logic [2:0]    rel,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          br_sense,
  output logic          cc,
  output logic          br_taken
);
  import fpcmp_pkg::*;

  logic [DW-1:0] ops   [2];
  logic [MW-1:0] mag_v [2];
  logic [1:0]    nan_v, sign_v, zero_v;

  assign ops[0] = opa;
  assign ops[1] = opb;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fpcmp_classify #(.SE(SP_EXP), .SF(SP_FRAC), .DE(DP_EXP), .DF(DP_FRAC)) u_cls (
      .op(ops[g]), .dbl(fmt_dbl), .nan(nan_v[g]), .sign(sign_v[g]),
      .zero(zero_v[g]), .mag(mag_v[g])
    );
  end

  // Named internal events for the checker.
  logic nan_any, zero_both, ord_lt, ord_eq, cc_next;
  assign nan_any   = |nan_v;
  assign zero_both = &zero_v;

  fpcmp_order #(.MW(MW)) u_ord (
    .sa(sign_v[0]), .sb(sign_v[1]), .za(zero_v[0]), .zb(zero_v[1]),
    .ma(mag_v[0]), .mb(mag_v[1]), .lt(ord_lt), .eq(ord_eq)
  );

  assign cc_next = !nan_any && rel_hit(rel, ord_lt, ord_eq);

  fpcmp_ccreg u_cc (.clk(clk), .rst_n(rst_n), .en(cmp_en), .d(cc_next), .q(cc));

  assign br_taken = ~(cc ^ br_sense);
endmodule

// File: rtl/fpcmp_chk.sv
module fpcmp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmp_en,
  input logic [2:0] rel,
  input logic       br_sense,
  input logic       cc,
  input logic       br_taken,
  input logic       nan_any,
  input logic       zero_both,
  input logic       ord_lt,
  input logic       ord_eq
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> $stable(cc));

  assert_reset_clear_R7: assert property (@(posedge clk)
    !rst_n |=> !cc);

  assert_nan_false_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en && nan_any |=> !cc);

  assert_zero_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_both |-> ord_eq);

  assert_order_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ord_eq |-> !ord_lt);

  assert_ge_complement_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en && !nan_any && rel == 3'd4 |=> cc == !$past(ord_lt));

  assert_branch_true_R8: assert property (@(posedge clk) disable iff (!rst_n)
    br_sense |-> br_taken == cc);

  assert_branch_false_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !br_sense |-> br_taken != cc);
endmodule

bind fp_cmp_cc fpcmp_chk u_fpcmp_chk (.*);

// File: tb/test_fp_cmp_cc.sv
module test_fp_cmp_cc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_en = 1'b0;
  logic        fmt_dbl = 1'b0;
  logic [2:0]  rel = 3'd0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic        br_sense = 1'b0;
  logic        cc, br_taken;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp_cmp_cc i_fp_cmp_cc (
    .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .fmt_dbl(fmt_dbl), .rel(rel),
    .opa(opa), .opb(opb), .br_sense(br_sense), .cc(cc), .br_taken(br_taken)
  );

  localparam int NV = 13;

  function automatic logic [31:0] sval(input int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h8000_0000;
      2: return 32'h3F80_0000;  3: return 32'hBF80_0000;
      4: return 32'h4000_0000;  5: return 32'hC000_0000;
      6: return 32'h7F80_0000;  7: return 32'hFF80_0000;
      8: return 32'h7FC0_0000;  9: return 32'h7F80_0001;
      10: return 32'h0000_0001; 11: return 32'h8000_0001;
      default: return 32'h7F7F_FFFF;
    endcase
  endfunction

  function automatic logic [63:0] dval(input int i);
    case (i)
      0: return 64'h0;                    1: return 64'h8000_0000_0000_0000;
      2: return 64'h3FF0_0000_0000_0000;  3: return 64'hBFF0_0000_0000_0000;
      4: return 64'h4000_0000_0000_0000;  5: return 64'hC000_0000_0000_0000;
      6: return 64'h7FF0_0000_0000_0000;  7: return 64'hFFF0_0000_0000_0000;
      8: return 64'h7FF8_0000_0000_0000;  9: return 64'h7FF0_0000_0000_0001;
      10: return 64'h1;                   11: return 64'h8000_0000_0000_0001;
      default: return 64'h7FEF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  function automatic bit m_nan(input bit dbl, input logic [63:0] x);
    if (dbl) return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  // Signed ordering key: magnitude, negated when the sign bit is set.
  function automatic longint m_key(input bit dbl, input logic [63:0] x);
    longint m;
    bit s;
    m = dbl ? longint'({1'b0, x[62:0]}) : longint'({33'b0, x[30:0]});
    s = dbl ? x[63] : x[31];
    return s ? -m : m;
  endfunction

  function automatic bit m_cc(input bit dbl, input logic [2:0] r,
                              input logic [63:0] a, input logic [63:0] b);
    longint ka, kb;
    if (m_nan(dbl, a) || m_nan(dbl, b)) return 1'b0;
    ka = m_key(dbl, a);
    kb = m_key(dbl, b);
    case (r)
      3'd0: return ka == kb;
      3'd1: return ka > kb;
      3'd2: return ka < kb;
      3'd3: return ka <= kb;
      3'd4: return ka >= kb;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string m_tag(input bit dbl, input logic [2:0] r,
                                  input logic [63:0] a, input logic [63:0] b);
    longint ka, kb;
    if (m_nan(dbl, a) || m_nan(dbl, b)) return "R3";
    if (r > 3'd4) return "R1";
    ka = m_key(dbl, a);
    kb = m_key(dbl, b);
    if (ka == 0 && kb == 0) return "R4";
    if ((dbl ? (a[62:52] == 11'h7FF) : (a[30:23] == 8'hFF)) ||
        (dbl ? (b[62:52] == 11'h7FF) : (b[30:23] == 8'hFF))) return "R6";
    if (ka < 0 || kb < 0) return "R5";
    return "R1";
  endfunction

  task automatic chk(input bit got, input bit exp, input string tag, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, got, exp);
    end
  endtask

  // Drive at a falling edge, strobe through one rising edge, return at the next falling edge.
  task automatic do_cmp(input bit dbl, input logic [2:0] r,
                        input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    fmt_dbl = dbl; rel = r; opa = a; opb = b; cmp_en = 1'b1;
    @(negedge clk);
    cmp_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    bit e;
    repeat (3) @(negedge clk);
    chk(cc, 1'b0, "R7", "cc during reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(cc, 1'b0, "R7", "cc after reset");
    br_sense = 1'b0; #1;
    chk(br_taken, 1'b1, "R8", "branch-on-false after reset");

    // Full sweep: both formats, all value pairs, all relation codes.
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < NV; i++)
        for (int j = 0; j < NV; j++)
          for (int r = 0; r < 8; r++) begin
            if (f == 1) begin
              a = dval(i); b = dval(j);
            end else begin
              a = {((i + r) % 2 == 1) ? 32'hA5C3_0F96 : 32'h0, sval(i)};
              b = {((j + r) % 3 == 1) ? 32'h7FF8_1234 : 32'h0, sval(j)};
            end
            e = m_cc(f[0], r[2:0], a, b);
            do_cmp(f[0], r[2:0], a, b);
            chk(cc, e, m_tag(f[0], r[2:0], a, b),
                $sformatf("fmt=%0d rel=%0d a=%h b=%h", f, r, a, b));
            if (r == 0) begin
              br_sense = j[0]; #1;
              chk(br_taken, (e == j[0]), "R8", $sformatf("branch sense=%0d", j[0]));
            end
          end

    // R9: lt and ge give opposite results on ordered operands, both false on NaN.
    do_cmp(1'b1, 3'd2, dval(3), dval(2));
    chk(cc, 1'b1, "R9", "-1 lt +1");
    do_cmp(1'b1, 3'd4, dval(3), dval(2));
    chk(cc, 1'b0, "R9", "-1 ge +1");
    do_cmp(1'b0, 3'd2, 64'(sval(8)), 64'(sval(2)));
    chk(cc, 1'b0, "R9", "nan lt 1");
    do_cmp(1'b0, 3'd4, 64'(sval(8)), 64'(sval(2)));
    chk(cc, 1'b0, "R9", "nan ge 1");

    // R2: upper bits ignored in single format, but meaningful in double.
    a = {32'h7FF8_0000, 32'h3F80_0000};
    b = {32'h0000_0000, 32'h3F80_0000};
    do_cmp(1'b0, 3'd0, a, b);
    chk(cc, 1'b1, "R2", "single eq ignores high half");
    do_cmp(1'b1, 3'd0, a, b);
    chk(cc, 1'b0, "R2", "same bits as double nan");

    // R7: hold while strobe is low, even with operands that would flip it.
    do_cmp(1'b1, 3'd0, dval(2), dval(2));
    chk(cc, 1'b1, "R7", "set before hold");
    fmt_dbl = 1'b1; rel = 3'd0; opa = dval(2); opb = dval(4);
    repeat (4) @(negedge clk);
    chk(cc, 1'b1, "R7", "held with strobe low");

    // R8: branch read and compare strobe in the same cycle.
    br_sense = 1'b1;
    cmp_en = 1'b1; #1;
    chk(br_taken, 1'b1, "R8", "branch sees old cc before edge");
    @(negedge clk);
    cmp_en = 1'b0; #1;
    chk(br_taken, 1'b0, "R8", "branch sees new cc after edge");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule